// File: doc/BRIEF.md
# Manchester Serial Transmitter with Holding Register

This block is a host-programmed serial transmitter. The host writes a byte into a holding register over a small register bus. When the serial engine is free, the byte moves into a shift register and goes out on a single line in Manchester code. A new byte can be queued while the current one is being sent. The line rate is taken from the bus clock through a fixed base divide and a two-bit rate code.

Two status flags let software pace the traffic. The empty flag shows that the holding register can take a new byte. The complete flag shows that the line has gone idle with nothing left to send. The empty flag is cleared only by a fixed handshake: the host reads the status register while the flag is set, then writes the data register. The complete flag can drive an interrupt output when enabled. Register map: address 0 is the control register, address 1 is the status register, and address 2 is the data register.

Top module: `mtx_encoder`

## Requirements
- R1: After reset, status reads 8'hC0 (empty and complete set), control reads 8'h00, and both `ser_out` and `irq` are low.
- R2: One half-bit unit lasts (DIV_BASE/2)·2^(3−rate) clocks, where rate is control bits [1:0]. Code 3 sends one NRZ bit every DIV_BASE clocks. Codes 2, 1 and 0 run at one half, one quarter and one eighth of that.
- R3: Each data bit is two half-bit units of opposite level: a 1 is sent high then low, and a 0 low then high. The most significant bit goes first.
- R4: The empty flag (status bit 7) sets on the clock edge where the holding register is moved into the shift register.
- R5: A data write clears the empty flag only if a status read with the flag set came before it. A data write with no such read still queues the byte for sending, but the flag stays set.
- R6: Writing the data register while a byte is still waiting replaces that byte. Only the latest byte is sent.
- R7: The complete flag (status bit 6) sets once the last half-bit of a byte has ended with no byte waiting. It clears on the next load into the shift register.
- R8: A byte that is waiting when the current byte ends is loaded on that same edge, so the line carries no gap between the two.
- R9: While nothing is being sent, `ser_out` is low.
- R10: With control bit 7 set, `irq` is high one clock after the complete flag is high, and it follows that flag with a one-clock lag. With control bit 7 clear, `irq` is low.
- R11: Control bit 7 (interrupt enable) and bits [1:0] (rate) read back as written, and the other control bits read as 0. Status bits 5..0 read as 0. Read data is registered and appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ser_out | output | 1 | Manchester serial line |
| irq | output | 1 | Complete interrupt, registered |

## Verification
The assertions check the following on every cycle:
- the line is low whenever the engine is idle;
- the level flips at the middle of each bit;
- the line holds steady between half-bit ticks;
- the empty flag falls only after the armed handshake, and rises only on a load;
- the complete flag rises only when a byte ends with nothing queued;
- a byte that is waiting at the end of the current byte is always picked up.

Only the bench scenarios can show the rest: the exact length of each half-bit for every rate code, the exact bit pattern sent for every byte value, the replacement of a queued byte, the flag values that software reads at each point of the handshake, and the one-clock lag of the interrupt.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_IEN_BIT   = 7;
  localparam int STAT_EMPTY_BIT = 7;
  localparam int STAT_DONE_BIT  = 6;

  typedef struct packed {
    logic       ien;
    logic [1:0] rate;
  } mtx_cfg_t;
endpackage

// File: rtl/mtx_baud.sv
module mtx_baud #(
  parameter int DIV_BASE = 372
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int HALF_BASE = DIV_BASE / 2;
  localparam int MAX_HALF  = HALF_BASE * 8;
  localparam int CNT_W     = $clog2(MAX_HALF);
  localparam int LW        = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LW-1:0]    half_len;
  logic [1:0]       shamt;

  always_comb begin
    shamt    = 2'd3 - rate;
    half_len = LW'(HALF_BASE) << shamt;
    // >= so that a rate change in the middle of a unit never makes the counter wrap
    tick     = run && ({1'b0, cnt_q} >= (half_len - LW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mtx_shifter.sv
module mtx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] hold_byte,
  output logic              load,
  output logic              done,
  output logic              busy,
  output logic              ser_out
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, phase_q, out_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sreg_q;
  logic              last_unit;

  always_comb begin
    last_unit = busy_q && tick && phase_q && (bit_q == LAST_BIT);
    load      = pending && (!busy_q || last_unit);
    done      = last_unit && !pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      sreg_q  <= '0;
      out_q   <= 1'b0;
    end else if (load) begin
      sreg_q  <= hold_byte;
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      bit_q   <= '0;
      out_q   <= hold_byte[DATA_W-1];
    end else if (done) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (busy_q && tick) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
        out_q   <= ~sreg_q[DATA_W-1];
      end else begin
        phase_q <= 1'b0;
        bit_q   <= bit_q + BIT_W'(1);
        sreg_q  <= sreg_q << 1;
        out_q   <= sreg_q[DATA_W-2];
      end
    end
  end

  assign busy    = busy_q;
  assign ser_out = out_q;

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !out_q);

  // R3
  mid_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick && !phase_q) |=> (out_q != $past(out_q)));

  // R3
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> $stable(out_q));

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (last_unit && pending) |=> busy_q);
endmodule

// File: rtl/mtx_regs.sv
module mtx_regs
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              load,
  input  logic              done,
  output logic [DATA_W-1:0] hold_byte,
  output logic              pending,
  output mtx_cfg_t          cfg,
  output logic              irq
);
  mtx_cfg_t          cfg_q;
  logic [DATA_W-1:0] hold_q, rdata_q, rd_mux;
  logic              pend_q, empty_q, cmpl_q, arm_q, irq_q;
  logic              wr_ctrl, wr_data, rd_stat;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[CTRL_IEN_BIT-1:2];

  always_comb begin
    wr_ctrl = wr && (addr == ADDR_CTRL);
    wr_data = wr && (addr == ADDR_DATA);
    rd_stat = rd && (addr == ADDR_STAT);
    rd_mux  = '0;
    case (addr)
      ADDR_CTRL: begin
        rd_mux[CTRL_IEN_BIT] = cfg_q.ien;
        rd_mux[1:0]          = cfg_q.rate;
      end
      ADDR_STAT: begin
        rd_mux[STAT_EMPTY_BIT] = empty_q;
        rd_mux[STAT_DONE_BIT]  = cmpl_q;
      end
      ADDR_DATA: rd_mux = hold_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
      cmpl_q  <= 1'b1;
      arm_q   <= 1'b0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q <= '{ien: wdata[CTRL_IEN_BIT], rate: wdata[1:0]};

      if (wr_data) begin
        hold_q <= wdata;
        pend_q <= 1'b1;
      end else if (load) begin
        pend_q <= 1'b0;
      end

      if (wr_data)                 arm_q <= 1'b0;
      else if (rd_stat && empty_q) arm_q <= 1'b1;

      if (wr_data && arm_q) empty_q <= 1'b0;
      else if (load)        empty_q <= 1'b1;

      if (load)      cmpl_q <= 1'b0;
      else if (done) cmpl_q <= 1'b1;

      irq_q <= cfg_q.ien && cmpl_q;

      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata     = rdata_q;
  assign hold_byte = hold_q;
  assign pending   = pend_q;
  assign cfg       = cfg_q;
  assign irq       = irq_q;

  // R5
  empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_q) |-> $past(wr_data && arm_q));

  // R4
  empty_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_q) |-> $past(load));

  // R7
  cmpl_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmpl_q) |-> $past(done));

  // R7
  cmpl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmpl_q) |-> $past(load));
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
  import mtx_pkg::*;
#(
  parameter int DIV_BASE = 372,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_out,
  output logic              irq
);
  mtx_cfg_t          cfg;
  logic [DATA_W-1:0] hold_byte;
  logic              pending, load, done, busy, tick;

  mtx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .load(load), .done(done),
    .hold_byte(hold_byte), .pending(pending), .cfg(cfg), .irq(irq)
  );

  mtx_baud #(.DIV_BASE(DIV_BASE)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .rate(cfg.rate), .tick(tick)
  );

  mtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .pending(pending),
    .hold_byte(hold_byte), .load(load), .done(done), .busy(busy),
    .ser_out(ser_out)
  );
endmodule

// File: tb/mtx_encoder_tb.sv
module mtx_encoder_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_out, irq;

  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  mtx_encoder #(.DIV_BASE(DIV), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_out(ser_out), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic send_armed(input logic [7:0] b);
    logic [7:0] s;
    rd_reg(2'd1, s);
    wr_reg(2'd2, b);
  endtask

  // R2 R3 R8 R9: compare the line cycle by cycle against the expected Manchester pattern
  task automatic watch(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input int rate, input string req);
    int h, bad, fa, fe;
    logic [7:0] cur;
    logic lvl;
    h = (DIV / 2) << (3 - rate);
    bad = 0; fa = 0; fe = 0;
    for (int i = 0; i < n; i++) begin
      cur = (i == 0) ? b0 : b1;
      for (int k = 0; k < 16; k++) begin
        lvl = cur[7 - k/2] ^ k[0];
        for (int j = 0; j < h; j++) begin
          @(negedge clk);
          if (ser_out !== lvl && bad == 0) begin
            bad = 1; fa = int'(ser_out); fe = int'(lvl);
          end
        end
      end
    end
    if (bad != 0) chk(req, fa, fe); else chk(req, 0, 0);
    @(negedge clk);
    chk("R9 idle low", int'(ser_out), 0);
  endtask

  logic [7:0] s;

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 ser_out", int'(ser_out), 0);
    chk("R1 irq", int'(irq), 0);
    rd_reg(2'd1, s); chk("R1 status", s, 8'hC0);
    rd_reg(2'd0, s); chk("R1 ctrl", s, 8'h00);
    // R11
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, s); chk("R11 ctrl mask", s, 8'h83);
    wr_reg(2'd0, 8'h00);

    // R2 R3: slower rates with selected patterns
    for (int r = 0; r < 3; r++) begin
      wr_reg(2'd0, 8'(r));
      for (int p = 0; p < 4; p++) begin
        logic [7:0] b;
        b = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h96;
        send_armed(b);
        watch(1, b, 8'h00, r, "R2/R3 rate waveform");
        rd_reg(2'd1, s); chk("R7 complete after byte", s, 8'hC0);
      end
    end

    // R3: every byte value at the fastest rate
    wr_reg(2'd0, 8'h03);
    for (int v = 0; v < 256; v++) begin
      send_armed(8'(v));
      watch(1, 8'(v), 8'h00, 3, "R3 byte sweep");
    end
    rd_reg(2'd1, s); chk("R7 status idle", s, 8'hC0);

    // R8 R4 R5 R7: back-to-back bytes with the armed handshake
    send_armed(8'h3A);
    fork
      watch(2, 8'h3A, 8'hC5, 3, "R8 back-to-back");
      begin
        @(negedge clk);
        rd_reg(2'd1, s);
        chk("R4 empty after load", int'(s[7]), 1);
        chk("R7 complete cleared on load", int'(s[6]), 0);
        wr_reg(2'd2, 8'hC5);
        rd_reg(2'd1, s);
        chk("R5 empty cleared by armed write", int'(s[7]), 0);
      end
    join
    rd_reg(2'd1, s); chk("R7 status after pair", s, 8'hC0);

    // R6: overwrite of a waiting byte
    send_armed(8'hF0);
    fork
      watch(2, 8'hF0, 8'h69, 3, "R6 overwrite");
      begin
        @(negedge clk);
        rd_reg(2'd1, s);
        wr_reg(2'd2, 8'h11);
        wr_reg(2'd2, 8'h69);
        rd_reg(2'd1, s);
        chk("R6 empty stays clear", int'(s[7]), 0);
      end
    join

    // R5: write without a prior status read keeps the empty flag set
    send_armed(8'h81);
    fork
      watch(2, 8'h81, 8'h7E, 3, "R5 unarmed byte still sent");
      begin
        @(negedge clk);
        @(negedge clk);
        wr_reg(2'd2, 8'h7E);
        rd_reg(2'd1, s);
        chk("R5 unarmed write keeps empty", int'(s[7]), 1);
      end
    join

    // R10: interrupt follows complete with one clock lag
    wr_reg(2'd0, 8'h83);
    rd_reg(2'd0, s); chk("R11 ctrl readback", s, 8'h83);
    chk("R10 irq when idle and enabled", int'(irq), 1);
    send_armed(8'h3C);
    repeat (4) @(negedge clk);
    chk("R10 irq low while sending", int'(irq), 0);
    repeat (29) @(negedge clk);
    chk("R10 irq lag", int'(irq), 0);
    @(negedge clk);
    chk("R10 irq after complete", int'(irq), 1);
    chk("R9 line low at end", int'(ser_out), 0);
    wr_reg(2'd0, 8'h03);
    @(negedge clk);
    chk("R10 irq disabled", int'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule